// File: doc/BRIEF.md
# Queue-Scheduled Carry-Save Multiplier

This block is a purely combinational unsigned multiplier. It takes an X operand of M bits and a Y operand of N bits and returns their full product on M+N bits. Each operand width is parameterised. A width set below 2 is raised to 2 inside the parameter list, and the ports then take the raised width.

The datapath has three stages.

- **Partial products.** One shifted partial product is formed per bit of X, using two-input AND gates.
- **Reduction.** The partial products are placed in an operand queue. A chain of 3:2 carry-save steps then reduces them. Each step takes the three oldest operands still waiting and appends a sum vector and a carry vector to the end of the queue. The chain stops when exactly two operands remain. A multiplier of M rows therefore handles 3M-4 operands in all.
- **Final addition.** The last pair is folded into a half-sum U and a carry word V. A parallel-prefix adder then forms U + 2V.

Every logic gate in the network has exactly two inputs. The block is used wherever a product is needed within one cycle. Its inputs and output are registered by the surrounding logic.

Top module: `mulq_csa_array`

## Requirements
- R1: Output `z` equals the unsigned product `x * y` exactly, on M+N bits, for every input pair, where M and N are the port widths (each at least 2).
- R2: Partial product j (0 <= j < M) holds y shifted left by j where x[j] is 1. It is all zero where x[j] is 0. Bits below position j and at or above position j+N are always zero.
- R3: Reduction step k (0 <= k <= M-3) consumes queue entries 3k, 3k+1 and 3k+2 and writes entries M+2k (sum) and M+2k+1 (carry). When M is 2 there are no steps.
- R4: In each step, the sum vector plus the carry vector equals the sum of its three inputs, modulo 2^(M+N).
- R5: A carry vector is the bitwise majority of the three inputs, moved up one place. Bit 0 is zero, and the majority bit at position M+N-1 is dropped.
- R6: The result equals U + 2V modulo 2^(M+N), where U is the XOR and V is the AND of the last two queue entries.
- R7: The final adder returns the sum of its two M+N bit inputs modulo 2^(M+N).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | M | Multiplicand, unsigned |
| y | input | N | Multiplier, unsigned |
| z | output | M+N | Full unsigned product |

## Verification
The checks inside the design assume that `x` and `y` are settled two-state values. They assume nothing else about the operand values, because every code on the operand ports is legal. The stimulus drives each operand pair once per clock, away from the sampling edge, so the whole network has settled when the output is read.

The stimulus covers every operand pair for the 2x2, 3x5 and 4x4 widths. For the 8x8 and 16x12 widths it uses random pairs, plus the all-zero, all-one and single-bit operands. Those corners drive carries into the top bit, where the modulo drop of R5 and R6 takes effect.

// File: rtl/mulq_pkg.sv
package mulq_pkg;
  // Raise a requested operand width to the legal minimum of two bits.
  function automatic int clamp_width(input int req);
    return (req < 2) ? 2 : req;
  endfunction

  // Number of queue entries used by the reduction for m partial products.
  function automatic int queue_len(input int m);
    return 3 * m - 4;
  endfunction
endpackage

// File: rtl/mulq_pp_gen.sv
module mulq_pp_gen #(
  parameter int M = 2,
  parameter int N = 2,
  localparam int W = M + N
) (
  input  logic [M-1:0]         x,
  input  logic [N-1:0]         y,
  output logic [M-1:0][W-1:0]  pp
);
  for (genvar j = 0; j < M; j++) begin : g_row
    for (genvar k = 0; k < W; k++) begin : g_bit
      if (k >= j && k < j + N) begin : g_and
        assign pp[j][k] = x[j] & y[k-j];
      end else begin : g_zero
        assign pp[j][k] = 1'b0;
      end
    end

    // Row contents outside the shifted window, and rows gated off by x
    always_comb begin
      p_pp_low_zero_r2: assert ((pp[j] & ((W'(1) << j) - W'(1))) == '0)
        else $error("row %0d has bits below its shift", j);
      p_pp_gate_r2: assert (x[j] || (pp[j] == '0))
        else $error("row %0d nonzero while its x bit is 0", j);
      p_pp_high_zero_r2: assert ((pp[j] >> (j + N)) == '0)
        else $error("row %0d has bits above its window", j);
    end
  end
endmodule

// File: rtl/mulq_csa3.sv
module mulq_csa3 #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] half;
  logic [W-2:0] gen_ab;
  logic [W-2:0] gen_hc;

  // Two-input gates only: half-sum, then combine with the third input
  assign half   = a ^ b;
  assign gen_ab = a[W-2:0] & b[W-2:0];
  assign sum    = half ^ c;
  assign gen_hc = half[W-2:0] & c[W-2:0];
  assign carry  = {gen_ab | gen_hc, 1'b0};

  // Counting conservation of a 3:2 step, modulo the vector width
  always_comb begin
    p_csa_conserve_r4: assert (W'(sum + carry) == W'(a + b + c))
      else $error("3:2 step lost a count");
    p_csa_lsb_r5: assert (!carry[0] || $isunknown(carry))
      else $error("carry vector bit 0 set");
  end
endmodule

// File: rtl/mulq_prefix_add.sv
module mulq_prefix_add #(
  parameter int W = 4,
  localparam int CW = W - 1,
  localparam int LV = $clog2(CW)
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  logic [W-1:0]  hs;
  logic [CW-1:0] gen [0:LV];
  logic [CW-1:0] prp [0:LV-1];

  assign hs     = a ^ b;
  assign gen[0] = a[CW-1:0] & b[CW-1:0];
  assign prp[0] = hs[CW-1:0];

  // Log-depth group generate/propagate tree over the carry positions
  for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
    localparam int D = 1 << lv;
    for (genvar i = 0; i < CW; i++) begin : g_pos
      if (i >= D) begin : g_merge
        assign gen[lv+1][i] = gen[lv][i] | (prp[lv][i] & gen[lv][i-D]);
        if (lv + 1 < LV) begin : g_p
          assign prp[lv+1][i] = prp[lv][i] & prp[lv][i-D];
        end
      end else begin : g_pass
        assign gen[lv+1][i] = gen[lv][i];
        if (lv + 1 < LV) begin : g_p
          assign prp[lv+1][i] = prp[lv][i];
        end
      end
    end
  end

  assign s = hs ^ {gen[LV], 1'b0};

  always_comb begin
    p_adder_sum_r7: assert (s == W'(a + b))
      else $error("prefix adder sum wrong");
  end
endmodule

// File: rtl/mulq_csa_array.sv
module mulq_csa_array
  import mulq_pkg::*;
#(
  parameter int X_BITS = 8,
  parameter int Y_BITS = 8,
  localparam int M    = clamp_width(X_BITS),
  localparam int N    = clamp_width(Y_BITS),
  localparam int W    = M + N,
  localparam int NOPS = queue_len(M)
) (
  input  logic [M-1:0] x,
  input  logic [N-1:0] y,
  output logic [W-1:0] z
);
  logic [M-1:0][W-1:0] rows;
  logic [W-1:0]        opq [NOPS];
  logic [W-1:0]        u_half;
  logic [W-2:0]        v_gen;
  logic [W-1:0]        v_twice;

  mulq_pp_gen #(.M(M), .N(N)) u_pp (
    .x  (x),
    .y  (y),
    .pp (rows)
  );

  // The first M queue entries are the partial products
  for (genvar j = 0; j < M; j++) begin : g_load
    assign opq[j] = rows[j];
  end

  // FIFO schedule: step k eats entries 3k..3k+2 and appends two
  for (genvar k = 0; k < M - 2; k++) begin : g_step
    mulq_csa3 #(.W(W)) u_csa (
      .a     (opq[3*k]),
      .b     (opq[3*k+1]),
      .c     (opq[3*k+2]),
      .sum   (opq[M+2*k]),
      .carry (opq[M+2*k+1])
    );

    // Step result keeps the running total of the queue consistent
    always_comb begin
      p_step_sched_r3: assert (W'(opq[M+2*k] + opq[M+2*k+1]) ==
                               W'(opq[3*k] + opq[3*k+1] + opq[3*k+2]))
        else $error("step %0d wrote the wrong queue slots", k);
    end
  end

  // Last pair folded into half-sum and doubled generate word
  assign u_half  = opq[NOPS-2] ^ opq[NOPS-1];
  assign v_gen   = opq[NOPS-2][W-2:0] & opq[NOPS-1][W-2:0];
  assign v_twice = {v_gen, 1'b0};

  mulq_prefix_add #(.W(W)) u_add (
    .a (u_half),
    .b (v_twice),
    .s (z)
  );

  always_comb begin
    p_final_pair_r6: assert (z == W'(opq[NOPS-2] + opq[NOPS-1]))
      else $error("final U+2V mismatch");
    p_product_r1: assert (z == (W'(x) * W'(y)))
      else $error("product mismatch");
  end
endmodule

// File: tb/sim_mulq_csa_array.sv
module sim_mulq_csa_array;
  logic clk;
  logic [15:0] xb;
  logic [15:0] yb;
  logic [15:0] z0;
  logic [3:0]  z1;
  logic [7:0]  z2;
  logic [7:0]  z3;
  logic [27:0] z4;
  int n_vec;
  int n_bad;
  bit done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  mulq_csa_array #(.X_BITS(8),  .Y_BITS(8))  u0 (.x(xb[7:0]),  .y(yb[7:0]),  .z(z0));
  mulq_csa_array #(.X_BITS(2),  .Y_BITS(2))  u1 (.x(xb[1:0]),  .y(yb[1:0]),  .z(z1));
  mulq_csa_array #(.X_BITS(3),  .Y_BITS(5))  u2 (.x(xb[2:0]),  .y(yb[4:0]),  .z(z2));
  mulq_csa_array #(.X_BITS(4),  .Y_BITS(4))  u3 (.x(xb[3:0]),  .y(yb[3:0]),  .z(z3));
  mulq_csa_array #(.X_BITS(16), .Y_BITS(12)) u4 (.x(xb[15:0]), .y(yb[11:0]), .z(z4));

  // Behavioural model: a FIFO of integers reduced three at a time
  function automatic longint ref_queue(input int m, input int n,
                                       input longint xv, input longint yv);
    longint msk;
    longint q[$];
    longint a;
    longint b;
    longint c;
    msk = (longint'(1) << (m + n)) - 1;
    for (int j = 0; j < m; j++)
      q.push_back((((xv >> j) & 1) != 0) ? ((yv << j) & msk) : 0);
    while (q.size() > 2) begin
      a = q.pop_front();
      b = q.pop_front();
      c = q.pop_front();
      q.push_back(a ^ b ^ c);
      q.push_back((((a & b) | (a & c) | (b & c)) << 1) & msk);
    end
    return (q[0] + q[1]) & msk;
  endfunction

  task automatic apply(input int cfg, input longint xv, input longint yv,
                       input string req);
    int m;
    int n;
    longint got;
    longint exp_q;
    longint exp_m;
    @(posedge clk);
    xb <= xv[15:0];
    yb <= yv[15:0];
    @(negedge clk);
    case (cfg)
      0: begin m = 8;  n = 8;  got = longint'(z0); end
      1: begin m = 2;  n = 2;  got = longint'(z1); end
      2: begin m = 3;  n = 5;  got = longint'(z2); end
      3: begin m = 4;  n = 4;  got = longint'(z3); end
      default: begin m = 16; n = 12; got = longint'(z4); end
    endcase
    xv = xv & ((longint'(1) << m) - 1);
    yv = yv & ((longint'(1) << n) - 1);
    exp_q = ref_queue(m, n, xv, yv);
    exp_m = xv * yv;
    n_vec++;
    if (got != exp_q || got != exp_m) begin
      n_bad++;
      $display("FAIL %s %0dx%0d x=%0d y=%0d got=%0d expected=%0d",
               req, m, n, xv, yv, got, exp_m);
    end
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    done  = 1'b0;
    xb = '0;
    yb = '0;
    // R2 / R1: all-zero operands give zero on every width
    for (int c = 0; c < 5; c++) apply(c, 0, 0, "R2");
    // R3: M=2 has no reduction step, exhaustive
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) apply(1, a, b, "R3");
    // R4: 3x5 exhaustive through one step
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 32; b++) apply(2, a, b, "R4");
    // R1: 4x4 exhaustive
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) apply(3, a, b, "R1");
    // R5 / R6: all ones push carries into the top bit
    apply(0, 255, 255, "R5");
    apply(4, 65535, 4095, "R5");
    apply(4, 32768, 2048, "R6");
    apply(0, 128, 1, "R2");
    // R7: random wide vectors
    for (int i = 0; i < 600; i++) apply(0, $urandom, $urandom, "R7");
    for (int i = 0; i < 600; i++) apply(4, $urandom, $urandom, "R1");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule